// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Block

This block holds the software-visible interrupt state of a flash memory controller. It has four registers: a controller status word with four error flags, an interrupt status word with a master pending bit and per-cause bits, and two system configuration words. It also keeps the last accepted command code. Software reaches these registers through a simple 16-bit word-addressed bus with separate write and read strobes. Read data is registered and returns one cycle after the read strobe.

A neighbouring command engine reports events as one-cycle pulses: operation completions and operation errors. Each completion sets the master interrupt bit and its cause bit. Each error sets its own error flag. Software acknowledges an interrupt by writing an AND mask to the interrupt status word. Any acknowledge that leaves the master bit clear also wipes every error flag.

A command written while the master bit is set is refused. An accepted command is passed to the engine as a one-cycle strobe. The interrupt pin is registered, and one configuration bit selects its polarity. A ready pin follows a second configuration bit. A warm-reset pulse from the engine restores the register defaults with a different interrupt signature than the asynchronous cold reset.

Top module: `flash_irq_regs`

## Requirements
- R1: After the asynchronous cold reset, the registers read as follows: configuration word 1 = 0x40C0, configuration word 2 = 0x0000, status = 0x0000, interrupt status = 0x8080, command = 0x0000. Both irq and rdy are 1.
- R2: A warm_rst pulse sets interrupt status to 0x8010 on the next edge. It also returns configuration word 1 to 0x40C0 and clears configuration word 2, status and the command register. rdy returns to 1.
- R3: A bus write to the interrupt status word (offset 4) replaces its value with the old value ANDed with the written data.
- R4: When a write to the interrupt status word leaves bit 15 clear, status bits 10..13 are cleared. When bit 15 stays set after the write, those status bits are kept.
- R5: done_erase sets interrupt bits 15 and 5, done_prog sets bits 15 and 6, done_load sets bits 15 and 7, and done_plain sets only bit 15. A hardware set in the same cycle as a clearing software write wins.
- R6: err_erase sets status bits 11 and 10, err_prog sets bits 12 and 10, and err_load sets bits 13 and 10. err_cmd sets status bit 10 and interrupt bit 15. Error flags stay set until cleared as in R4. An error set in the same cycle as that clear wins.
- R7: irq equals interrupt bit 15 XOR NOT configuration word 1 bit 6. It changes one clock cycle after either of those bits changes.
- R8: A write to configuration word 1 (offset 1) sets rdy to the written bit 7 on the same edge.
- R9: A write to the command word (offset 0) is ignored while interrupt bit 15 is set: the command word is not updated and cmd_fire is not raised. An accepted write raises cmd_fire for exactly one cycle after the edge, with cmd_code holding the written value.
- R10: The register offsets are: command 0, configuration word 1 at 1, configuration word 2 at 2, status at 3 (read-only), interrupt status at 4. A read of configuration word 1 returns bits 4..0 as zero. A read of any other offset returns 0. bus_rdata is valid from the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| warm_rst | input | 1 | One-cycle warm reset request from the command engine |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register word offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| done_erase | input | 1 | Erase completed pulse |
| done_prog | input | 1 | Program completed pulse |
| done_load | input | 1 | Load completed pulse |
| done_plain | input | 1 | Completion without a cause bit |
| err_erase | input | 1 | Erase failure pulse |
| err_prog | input | 1 | Program failure pulse |
| err_load | input | 1 | Load failure pulse |
| err_cmd | input | 1 | Unrecognised command pulse |
| cmd_fire | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 16 | Last accepted command code |
| irq | output | 1 | Interrupt pin, polarity set by configuration |
| rdy | output | 1 | Ready pin |

## Verification
A corrupted interrupt status word is visible in two places. It appears on the irq pin one cycle later, and it appears in the next read of offset 4. A wrong master bit also shows at once in whether the next command write raises cmd_fire. A wrong error flag shows only when status is read. For that reason the bench reads status after every event and acknowledge that could touch the error flags. The bench also drives same-cycle races between hardware sets and software clears, because a priority inversion there leaves the flags wrong only until the next event.

// File: rtl/flreg_pkg.sv
package flreg_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned NUM_REGS = 5;

  // register word offsets
  localparam int unsigned IDX_CMD  = 0;
  localparam int unsigned IDX_CFG1 = 1;
  localparam int unsigned IDX_CFG2 = 2;
  localparam int unsigned IDX_STAT = 3;
  localparam int unsigned IDX_INT  = 4;

  // interrupt status bit positions
  localparam int unsigned INT_MASTER_B = 15;
  localparam int unsigned INT_RST_B    = 4;
  localparam int unsigned INT_ERASE_B  = 5;
  localparam int unsigned INT_PROG_B   = 6;
  localparam int unsigned INT_LOAD_B   = 7;

  // status error flag positions
  localparam int unsigned ERR_CMD_B   = 10;
  localparam int unsigned ERR_ERASE_B = 11;
  localparam int unsigned ERR_PROG_B  = 12;
  localparam int unsigned ERR_LOAD_B  = 13;

  // configuration word 1 fields
  localparam int unsigned CFG_POL_B    = 6;
  localparam int unsigned CFG_RDY_B    = 7;
  localparam int unsigned CFG_RD_ZEROS = 5;

  localparam logic [WORD_W-1:0] ERR_MASK  =
    (WORD_W'(1) << ERR_CMD_B) | (WORD_W'(1) << ERR_ERASE_B) |
    (WORD_W'(1) << ERR_PROG_B) | (WORD_W'(1) << ERR_LOAD_B);
  localparam logic [WORD_W-1:0] CFG1_DEFAULT = 16'h40C0;
  localparam logic [WORD_W-1:0] CFG2_DEFAULT = 16'h0000;
  localparam logic [WORD_W-1:0] INT_COLD_VAL =
    (WORD_W'(1) << INT_MASTER_B) | (WORD_W'(1) << INT_LOAD_B);
  localparam logic [WORD_W-1:0] INT_WARM_VAL =
    (WORD_W'(1) << INT_MASTER_B) | (WORD_W'(1) << INT_RST_B);
  localparam logic [WORD_W-1:0] CFG1_RD_MASK = ~((WORD_W'(1) << CFG_RD_ZEROS) - WORD_W'(1));
endpackage

// File: rtl/flreg_decode.sv
module flreg_decode
  import flreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic [NUM_REGS-1:0] rd_hit
);
  logic [NUM_REGS-1:0] addr_match;

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_match
      assign addr_match[gi] = (bus_addr == ADDR_W'(gi));
    end
  endgenerate

  always_comb begin
    wr_hit = addr_match & {NUM_REGS{bus_wr}};
    rd_hit = addr_match & {NUM_REGS{bus_rd}};
  end
endmodule

// File: rtl/flreg_intstat.sv
module flreg_intstat
  import flreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done_erase,
  input  logic              done_prog,
  input  logic              done_load,
  input  logic              done_plain,
  input  logic              err_cmd,
  input  logic              pol_high,
  output logic [WORD_W-1:0] int_q,
  output logic              clr_errs,
  output logic              irq_q
);
  logic [WORD_W-1:0] hw_set;
  logic [WORD_W-1:0] int_d;
  logic              int_en;
  logic              irq_d;

  always_comb begin
    hw_set               = '0;
    hw_set[INT_ERASE_B]  = done_erase;
    hw_set[INT_PROG_B]   = done_prog;
    hw_set[INT_LOAD_B]   = done_load;
    hw_set[INT_MASTER_B] = done_erase | done_prog | done_load | done_plain | err_cmd;

    if (warm_rst) begin
      int_d = INT_WARM_VAL;
    end else if (wr_en) begin
      int_d = (int_q & wdata) | hw_set;
    end else begin
      int_d = int_q | hw_set;
    end
    int_en   = warm_rst | wr_en | (|hw_set);
    clr_errs = wr_en && !warm_rst && !int_d[INT_MASTER_B];
    irq_d    = int_q[INT_MASTER_B] ^ ~pol_high;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= INT_COLD_VAL;
      irq_q <= 1'b1;
    end else begin
      if (int_en) begin
        int_q <= int_d;
      end
      irq_q <= irq_d;
    end
  end

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_load && !warm_rst) |=> (int_q[INT_MASTER_B] && int_q[INT_LOAD_B])); // R5
  AST_AND_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !warm_rst && !(done_erase || done_prog || done_load || done_plain || err_cmd))
      |=> (int_q == ($past(int_q) & $past(wdata)))); // R3
  AST_WARM_SIG: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (int_q == INT_WARM_VAL)); // R2
endmodule

// File: rtl/flreg_errstat.sv
module flreg_errstat
  import flreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              clr_errs,
  input  logic              err_erase,
  input  logic              err_prog,
  input  logic              err_load,
  input  logic              err_cmd,
  output logic [WORD_W-1:0] stat_q
);
  logic [WORD_W-1:0] err_set;
  logic [WORD_W-1:0] stat_d;
  logic              stat_en;
  logic              any_err;

  always_comb begin
    any_err              = err_erase | err_prog | err_load | err_cmd;
    err_set              = '0;
    err_set[ERR_CMD_B]   = any_err;
    err_set[ERR_ERASE_B] = err_erase;
    err_set[ERR_PROG_B]  = err_prog;
    err_set[ERR_LOAD_B]  = err_load;

    if (warm_rst) begin
      stat_d = '0;
    end else if (clr_errs) begin
      stat_d = (stat_q & ~ERR_MASK) | err_set;
    end else begin
      stat_d = stat_q | err_set;
    end
    stat_en = warm_rst | clr_errs | any_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_errs && !any_err && !warm_rst) |=> ((stat_q & ERR_MASK) == '0)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_errs && !warm_rst) |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R6
endmodule

// File: rtl/flreg_cfg.sv
module flreg_cfg
  import flreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              cfg1_wr,
  input  logic              cfg2_wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] cfg1_q,
  output logic [WORD_W-1:0] cfg2_q,
  output logic              rdy_q
);
  logic [WORD_W-1:0] cfg1_d;
  logic [WORD_W-1:0] cfg2_d;
  logic              rdy_d;
  logic              cfg1_en;
  logic              cfg2_en;

  always_comb begin
    cfg1_en = warm_rst | cfg1_wr;
    cfg2_en = warm_rst | cfg2_wr;
    cfg1_d  = warm_rst ? CFG1_DEFAULT : wdata;
    cfg2_d  = warm_rst ? CFG2_DEFAULT : wdata;
    rdy_d   = warm_rst ? 1'b1 : wdata[CFG_RDY_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg1_q <= CFG1_DEFAULT;
      cfg2_q <= CFG2_DEFAULT;
      rdy_q  <= 1'b1;
    end else begin
      if (cfg1_en) begin
        cfg1_q <= cfg1_d;
        rdy_q  <= rdy_d;
      end
      if (cfg2_en) begin
        cfg2_q <= cfg2_d;
      end
    end
  end

  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_wr && !warm_rst) |=> (rdy_q == $past(wdata[CFG_RDY_B]))); // R8
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
  import flreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              done_erase,
  input  logic              done_prog,
  input  logic              done_load,
  input  logic              done_plain,
  input  logic              err_erase,
  input  logic              err_prog,
  input  logic              err_load,
  input  logic              err_cmd,
  output logic              cmd_fire,
  output logic [15:0]       cmd_code,
  output logic              irq,
  output logic              rdy
);
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] rd_hit;
  logic [WORD_W-1:0]   int_q;
  logic [WORD_W-1:0]   stat_q;
  logic [WORD_W-1:0]   cfg1_q;
  logic [WORD_W-1:0]   cfg2_q;
  logic [WORD_W-1:0]   cmd_q;
  logic [WORD_W-1:0]   cmd_d;
  logic [WORD_W-1:0]   rdata_d;
  logic [WORD_W-1:0]   rdata_q;
  logic                clr_errs;
  logic                cmd_take;
  logic                cmd_en;
  logic                fire_q;
  logic                irq_q;
  logic                rdy_q;

  flreg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .wr_hit   (wr_hit),
    .rd_hit   (rd_hit)
  );

  flreg_intstat u_intstat (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .wr_en      (wr_hit[IDX_INT]),
    .wdata      (bus_wdata),
    .done_erase (done_erase),
    .done_prog  (done_prog),
    .done_load  (done_load),
    .done_plain (done_plain),
    .err_cmd    (err_cmd),
    .pol_high   (cfg1_q[CFG_POL_B]),
    .int_q      (int_q),
    .clr_errs   (clr_errs),
    .irq_q      (irq_q)
  );

  flreg_errstat u_errstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .warm_rst  (warm_rst),
    .clr_errs  (clr_errs),
    .err_erase (err_erase),
    .err_prog  (err_prog),
    .err_load  (err_load),
    .err_cmd   (err_cmd),
    .stat_q    (stat_q)
  );

  flreg_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_rst (warm_rst),
    .cfg1_wr  (wr_hit[IDX_CFG1]),
    .cfg2_wr  (wr_hit[IDX_CFG2]),
    .wdata    (bus_wdata),
    .cfg1_q   (cfg1_q),
    .cfg2_q   (cfg2_q),
    .rdy_q    (rdy_q)
  );

  // command gate and read mux
  always_comb begin
    cmd_take = wr_hit[IDX_CMD] && !int_q[INT_MASTER_B] && !warm_rst;
    cmd_en   = cmd_take | warm_rst;
    cmd_d    = warm_rst ? '0 : bus_wdata;

    rdata_d = '0;
    if (rd_hit[IDX_CMD])  rdata_d = cmd_q;
    if (rd_hit[IDX_CFG1]) rdata_d = cfg1_q & CFG1_RD_MASK;
    if (rd_hit[IDX_CFG2]) rdata_d = cfg2_q;
    if (rd_hit[IDX_STAT]) rdata_d = stat_q;
    if (rd_hit[IDX_INT])  rdata_d = int_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      fire_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (cmd_en) begin
        cmd_q <= cmd_d;
      end
      fire_q <= cmd_take;
      if (bus_rd) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign cmd_fire  = fire_q;
  assign cmd_code  = cmd_q;
  assign irq       = irq_q;
  assign rdy       = rdy_q;

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit[IDX_CMD] && int_q[INT_MASTER_B]) |=> (!cmd_fire && $stable(cmd_code))); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == ($past(int_q[INT_MASTER_B]) ^ !$past(cfg1_q[CFG_POL_B])))); // R7
  AST_CFG1_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit[IDX_CFG1] |=> (bus_rdata[CFG_RD_ZEROS-1:0] == '0)); // R10
  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire); // R9
endmodule

// File: tb/flash_irq_regs_bench.sv
`timescale 1ns/1ps
module flash_irq_regs_bench;
  localparam time CLK_PER = 20ns;

  logic        clk;
  logic        rst_n;
  logic        warm_rst;
  logic        bus_wr;
  logic        bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [7:0]  ev;
  logic        cmd_fire;
  logic [15:0] cmd_code;
  logic        irq;
  logic        rdy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic rd_seen = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  flash_irq_regs #(.ADDR_W(3)) u_flash_irq_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst   (warm_rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .done_erase (ev[0]),
    .done_prog  (ev[1]),
    .done_load  (ev[2]),
    .done_plain (ev[3]),
    .err_erase  (ev[4]),
    .err_prog   (ev[5]),
    .err_load   (ev[6]),
    .err_cmd    (ev[7]),
    .cmd_fire   (cmd_fire),
    .cmd_code   (cmd_code),
    .irq        (irq),
    .rdy        (rdy)
  );

  initial clk = 1'b0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data once the read has been sampled
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL scoreboard unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  // driver tasks start and end on a falling edge
  task automatic bus_write_ev(input logic [2:0] a, input logic [15:0] d, input logic [7:0] e);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ev = e;
    @(negedge clk);
    bus_wr = 1'b0; ev = '0;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_write_ev(a, d, 8'h00);
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] e);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    rst_n = 1'b0; warm_rst = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; ev = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 cold reset state
    check("R1 irq", {15'd0, irq}, 16'h0001);
    check("R1 rdy", {15'd0, rdy}, 16'h0001);
    bus_read(3'd1, 16'h40C0, "R1 cfg1");
    bus_read(3'd2, 16'h0000, "R1 cfg2");
    bus_read(3'd3, 16'h0000, "R1 status");
    bus_read(3'd4, 16'h8080, "R1 intstat");

    // R9 command refused while master bit set
    bus_write(3'd0, 16'h0055);
    check("R9 blocked fire", {15'd0, cmd_fire}, 16'h0000);
    bus_read(3'd0, 16'h0000, "R9 blocked cmd reg");

    // R3 AND acknowledge, R7 irq lag
    bus_write(3'd4, 16'h7FFF);
    check("R7 irq before lag", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R7 irq after lag", {15'd0, irq}, 16'h0000);
    bus_read(3'd4, 16'h0080, "R3 intstat and");

    // R9 accepted command
    bus_write(3'd0, 16'h00A5);
    check("R9 fire", {15'd0, cmd_fire}, 16'h0001);
    check("R9 code", cmd_code, 16'h00A5);
    @(negedge clk);
    check("R9 fire one cycle", {15'd0, cmd_fire}, 16'h0000);
    bus_read(3'd0, 16'h00A5, "R9 cmd reg");

    // R5 erase completion, R6 program error
    pulse(8'h01);
    bus_read(3'd4, 16'h80A0, "R5 erase done");
    pulse(8'h20);
    bus_read(3'd3, 16'h1400, "R6 prog error");
    bus_read(3'd4, 16'h80A0, "R6 intstat unchanged");

    // R4 flags kept while master stays set, wiped when it clears
    bus_write(3'd4, 16'hFFDF);
    bus_read(3'd4, 16'h8080, "R3 clear cause bit");
    bus_read(3'd3, 16'h1400, "R4 flags kept");
    bus_write(3'd4, 16'h0000);
    bus_read(3'd3, 16'h0000, "R4 flags wiped");
    bus_read(3'd4, 16'h0000, "R3 all clear");

    // R5 hardware set beats software clear
    bus_write_ev(3'd4, 16'h0000, 8'h04);
    bus_read(3'd4, 16'h8080, "R5 load done wins");
    bus_write(3'd4, 16'h0000);
    // R6 error set beats wipe
    bus_write_ev(3'd4, 16'h0000, 8'h10);
    bus_read(3'd3, 16'h0C00, "R6 erase error wins");
    bus_read(3'd4, 16'h0000, "R6 intstat no master");
    pulse(8'h80);
    bus_read(3'd4, 16'h8000, "R6 cmd error master");
    bus_read(3'd3, 16'h0C00, "R6 cmd error flag");
    bus_write(3'd4, 16'h0000);
    bus_read(3'd3, 16'h0000, "R4 wipe after cmd error");
    pulse(8'h08);
    bus_read(3'd4, 16'h8000, "R5 plain done");
    bus_write(3'd4, 16'h0000);

    // R7 polarity, R8 ready, R10 masked read
    bus_write(3'd1, 16'h0000);
    check("R8 rdy low", {15'd0, rdy}, 16'h0000);
    @(negedge clk);
    check("R7 active low idle", {15'd0, irq}, 16'h0001);
    bus_read(3'd1, 16'h0000, "R10 cfg1 zero");
    bus_write(3'd1, 16'h00BF);
    check("R8 rdy high", {15'd0, rdy}, 16'h0001);
    bus_read(3'd1, 16'h00A0, "R10 cfg1 low bits masked");
    pulse(8'h02);
    check("R7 irq lag active low", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    check("R7 irq asserted low", {15'd0, irq}, 16'h0000);
    bus_read(3'd4, 16'h8040, "R5 prog done");

    // R10 map
    bus_write(3'd2, 16'h1234);
    bus_read(3'd2, 16'h1234, "R10 cfg2");
    bus_write(3'd3, 16'hFFFF);
    bus_read(3'd3, 16'h0000, "R10 status read-only");
    bus_read(3'd7, 16'h0000, "R10 unmapped");

    // R2 warm reset
    pulse(8'h40);
    bus_read(3'd3, 16'h2400, "R6 load error");
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    check("R2 rdy", {15'd0, rdy}, 16'h0001);
    bus_read(3'd4, 16'h8010, "R2 intstat");
    bus_read(3'd1, 16'h40C0, "R2 cfg1");
    bus_read(3'd2, 16'h0000, "R2 cfg2");
    bus_read(3'd3, 16'h0000, "R2 status");
    bus_read(3'd0, 16'h0000, "R2 cmd reg");
    check("R7 irq after warm", {15'd0, irq}, 16'h0001);

    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard pending actual=%0d expected=0", exp_q.size());
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule